// File: doc/BRIEF.md
# Multiply-Accumulate Status Flag Unit

This block multiplies two signed 16-bit operands and adds the 32-bit product into a 40-bit running sum. The sum is a 32-bit accumulator with an 8-bit guard byte above it. Each operation also refreshes four status flags: negative, soft overflow, zero and hard overflow. Software loads the operands and can read or preload every byte of the sum and the status through a byte-wide register port. That port has an address, a write strobe and a combinational read. A separate control port starts an operation or clears the accumulator.

The work is split over two pipeline stages. The stage-one register captures the product on the edge that samples the start pulse. On the next edge, stage two adds the product into the sum and writes the flags. Hard overflow is sticky and catches the guard byte crossing between its largest positive and most negative values. Soft overflow tracks whether the sum still fits a signed 32-bit value, so it clears by itself once a later result is back in range.

Top module: `macStatusUnit`

## Requirements
- R1: After reset, all operand bytes, all accumulator bytes and the guard byte read 0x00, and the status register (address 9) reads 0x04.
- R2: Status bits 7:4 always read zero, and the value written to them has no effect.
- R3: With no operation in flight, a write to status address 9 loads bits 3:0 from the write data. Those bits are hard overflow (bit 3), zero (bit 2), soft overflow (bit 1) and negative (bit 0).
- R4: Operand A reads back as its low byte at address 0 and its high byte at address 1. Operand B reads back the same way at addresses 2 and 3.
- R5: A start pulse sampled on edge N captures the signed product A*B. On edge N+1 the product, sign-extended, is added to the 40-bit sum modulo 2^40. The sum is unchanged after edge N.
- R6: After each operation, the zero flag is 1 exactly when all 40 sum bits are zero.
- R7: After each operation, the negative flag equals sum bit 39.
- R8: After each operation, the soft overflow flag is 1 exactly when sum bits 39:31 are not all equal, so it returns to 0 once a later result fits in 32 signed bits.
- R9: Hard overflow sets when one operation moves the guard byte from 0x7F to 0x80 or from 0x80 to 0x7F. It otherwise keeps its value across operations.
- R10: Hard overflow is cleared only by a software status write with bit 3 at 0, or by the clear control.
- R11: The clear control zeroes the sum and sets the status to 0x04 on the next edge. It cancels an operation in stage two, and also a start pulse sampled on the same edge.
- R12: When a status write and a stage-two update land on the same edge, the status takes the hardware result.
- R13: Accumulator bytes at addresses 4 (least significant) to 7 and the guard byte at address 8 are software writable, and the written value is the base of the next addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register address for both reads and writes |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data byte |
| regRdData | output | 8 | Combinational read data of the addressed register |
| opStart | input | 1 | One-cycle pulse that starts a multiply-accumulate |
| accClear | input | 1 | Clears the sum, resets the flags and cancels in-flight work |

## Verification
The hardest state to reach from the ports is a hard overflow. Products are at most 2^30 in magnitude, so adding products alone cannot walk the guard byte from 0x7F to 0x80 within a short run. The bench therefore preloads the guard byte and the accumulator bytes through the register port to one unit below or at the crossing point, then runs plus or minus one times one. Two further cases are placed at chosen cycles: a status write on the very edge of a stage-two update, and a clear while a product waits in stage one. The bench also runs a 13-by-13 sweep of signed operand pairs, including the extreme values, and checks every sum byte and flag against an arithmetic model after each operation.

// File: rtl/macStatPkg.sv
package macStatPkg;

  localparam int OP_W   = 16;
  localparam int ACC_W  = 32;
  localparam int OVR_W  = 8;
  localparam int BYTE_W = 8;

  localparam int OP_BYTES  = OP_W / BYTE_W;
  localparam int ACC_BYTES = ACC_W / BYTE_W;
  localparam int SUM_W     = ACC_W + OVR_W;
  localparam int PROD_W    = 2 * OP_W;
  localparam int EXT_W     = SUM_W - PROD_W;

  localparam int A_BASE    = 0;
  localparam int B_BASE    = A_BASE + OP_BYTES;
  localparam int ACC_BASE  = B_BASE + OP_BYTES;
  localparam int OVR_ADDR  = ACC_BASE + ACC_BYTES;
  localparam int STAT_ADDR = OVR_ADDR + 1;
  localparam int NREG      = STAT_ADDR + 1;
  localparam int ADDR_W    = $clog2(NREG);

  localparam int FLAG_W    = 4;
  localparam int FLG_NEG   = 0;
  localparam int FLG_SOFT  = 1;
  localparam int FLG_ZERO  = 2;
  localparam int FLG_HARD  = 3;
  localparam logic [FLAG_W-1:0] STAT_RESET = 4'b0100;

  localparam logic [OVR_W-1:0] OVR_MAXPOS = {1'b0, {(OVR_W-1){1'b1}}};
  localparam logic [OVR_W-1:0] OVR_MINNEG = {1'b1, {(OVR_W-1){1'b0}}};

  typedef struct packed {
    logic [NREG-1:0] wrSel;
    logic            mulLoad;
    logic            accCommit;
    logic            accClear;
  } macStrobes_t;

endpackage

// File: rtl/macCtrl.sv
module macCtrl
  import macStatPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              opStart,
  input  logic              accClear,
  output macStrobes_t       strobes
);

  logic s1Valid;

  always_comb begin
    strobes = '0;
    for (int i = 0; i < NREG; i++) begin
      strobes.wrSel[i] = regWrEn && (regAddr == ADDR_W'(i));
    end
    strobes.mulLoad   = opStart && !accClear;
    strobes.accCommit = s1Valid && !accClear;
    strobes.accClear  = accClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) s1Valid <= 1'b0;
    else       s1Valid <= strobes.mulLoad;
  end

  AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mulLoad |=> (strobes.accCommit || accClear)); // R5

  AST_CLEAR_CANCELS: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && accClear) |=> !strobes.accCommit); // R11

endmodule

// File: rtl/macDatapath.sv
module macDatapath
  import macStatPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  macStrobes_t       strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData
);

  logic [OP_W-1:0]   opA;
  logic [OP_W-1:0]   opB;
  logic [PROD_W-1:0] prodQ;
  logic [PROD_W-1:0] prodNext;
  logic [SUM_W-1:0]  sumQ;
  logic [SUM_W-1:0]  sumNext;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] flagsNext;
  logic [OVR_W-1:0]  ovrOld;
  logic [OVR_W-1:0]  ovrNew;
  logic [OVR_W:0]    rangeBits;
  logic              crossing;

  // Operand registers, byte-writable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opA <= '0;
      opB <= '0;
    end else begin
      for (int i = 0; i < OP_BYTES; i++) begin
        if (strobes.wrSel[A_BASE+i]) opA[i*BYTE_W +: BYTE_W] <= wrData;
        if (strobes.wrSel[B_BASE+i]) opB[i*BYTE_W +: BYTE_W] <= wrData;
      end
    end
  end

  // Stage one: signed product.
  assign prodNext = $signed(opA) * $signed(opB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                prodQ <= '0;
    else if (strobes.mulLoad) prodQ <= prodNext;
  end

  // Stage two: accumulate and derive flags.
  always_comb begin
    sumNext   = sumQ + {{EXT_W{prodQ[PROD_W-1]}}, prodQ};
    ovrOld    = sumQ[SUM_W-1 -: OVR_W];
    ovrNew    = sumNext[SUM_W-1 -: OVR_W];
    rangeBits = sumNext[SUM_W-1:ACC_W-1];
    crossing  = ((ovrOld == OVR_MAXPOS) && (ovrNew == OVR_MINNEG)) ||
                ((ovrOld == OVR_MINNEG) && (ovrNew == OVR_MAXPOS));
    flagsNext           = '0;
    flagsNext[FLG_HARD] = flags[FLG_HARD] || crossing;
    flagsNext[FLG_ZERO] = (sumNext == '0);
    flagsNext[FLG_SOFT] = !((&rangeBits) || (~|rangeBits));
    flagsNext[FLG_NEG]  = sumNext[SUM_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ <= '0;
    end else if (strobes.accClear) begin
      sumQ <= '0;
    end else if (strobes.accCommit) begin
      sumQ <= sumNext;
    end else begin
      for (int i = 0; i < ACC_BYTES; i++) begin
        if (strobes.wrSel[ACC_BASE+i]) sumQ[i*BYTE_W +: BYTE_W] <= wrData;
      end
      if (strobes.wrSel[OVR_ADDR]) sumQ[SUM_W-1 -: OVR_W] <= wrData;
    end
  end

  // Hardware update outranks a software status write on the same edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          flags <= STAT_RESET;
    else if (strobes.accClear)          flags <= STAT_RESET;
    else if (strobes.accCommit)         flags <= flagsNext;
    else if (strobes.wrSel[STAT_ADDR])  flags <= wrData[FLAG_W-1:0];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < OP_BYTES; i++) begin
      if (regAddr == ADDR_W'(A_BASE + i)) rdData = opA[i*BYTE_W +: BYTE_W];
      if (regAddr == ADDR_W'(B_BASE + i)) rdData = opB[i*BYTE_W +: BYTE_W];
    end
    for (int i = 0; i < ACC_BYTES; i++) begin
      if (regAddr == ADDR_W'(ACC_BASE + i)) rdData = sumQ[i*BYTE_W +: BYTE_W];
    end
    if (regAddr == ADDR_W'(OVR_ADDR))  rdData = sumQ[SUM_W-1 -: OVR_W];
    if (regAddr == ADDR_W'(STAT_ADDR)) rdData = {{(BYTE_W-FLAG_W){1'b0}}, flags};
  end

  AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accClear |=> (sumQ == '0 && flags == STAT_RESET)); // R11

  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accCommit |=> (flags[FLG_ZERO] == (sumQ == '0))); // R6

  AST_NEG_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accCommit |=> (flags[FLG_NEG] == sumQ[SUM_W-1])); // R7

  AST_SOFT_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accCommit |=> (flags[FLG_SOFT] ==
      !((&sumQ[SUM_W-1:ACC_W-1]) || (~|sumQ[SUM_W-1:ACC_W-1])))); // R8

  AST_HARD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flags[FLG_HARD] && !strobes.accClear &&
     !(strobes.wrSel[STAT_ADDR] && !strobes.accCommit)) |=> flags[FLG_HARD]); // R9

  AST_STAT_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(STAT_ADDR)) |-> (rdData[BYTE_W-1:FLAG_W] == '0)); // R2

endmodule

// File: rtl/macStatusUnit.sv
module macStatusUnit
  import macStatPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [BYTE_W-1:0] regWrData,
  output logic [BYTE_W-1:0] regRdData,
  input  logic              opStart,
  input  logic              accClear
);

  macStrobes_t strobes;

  macCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .opStart  (opStart),
    .accClear (accClear),
    .strobes  (strobes)
  );

  macDatapath uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .regAddr (regAddr),
    .wrData  (regWrData),
    .rdData  (regRdData)
  );

endmodule

// File: tb/tb_macStatusUnit.sv
module tb_macStatusUnit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       opStart = 1'b0;
  logic       accClear = 1'b0;

  always #5 clk = ~clk;

  macStatusUnit dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .opStart(opStart), .accClear(accClear)
  );

  localparam longint MASK40 = 64'hFF_FFFF_FFFF;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  longint mAcc;
  int     mA, mB;
  bit     mHard, mZero, mSoft, mNeg;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [7:0] expStat();
    return {4'b0000, mHard, mZero, mSoft, mNeg};
  endfunction

  task automatic modelStep();
    longint p, s, oldO, newO, top;
    p = longint'(mA) * longint'(mB);
    s = (mAcc + p) & MASK40;
    oldO = (mAcc >> 32) & 64'hFF;
    newO = (s >> 32) & 64'hFF;
    if ((oldO == 64'h7F && newO == 64'h80) || (oldO == 64'h80 && newO == 64'h7F)) mHard = 1'b1;
    top = (s >> 31) & 64'h1FF;
    mZero = (s == 0);
    mNeg = s[39];
    mSoft = !(top == 0 || top == 64'h1FF);
    mAcc = s;
  endtask

  task automatic checkSum(input string req);
    logic [7:0] v;
    longint got = 0;
    for (int i = 0; i < 5; i++) begin
      rd(4'(4 + i), v);
      got = got | (longint'(v) << (8 * i));
    end
    chk(req, "sum", got, mAcc);
    rd(4'd9, v);
    chk(req, "status", longint'(v), longint'(expStat()));
  endtask

  task automatic setOps(input int a, input int b);
    wr(4'd0, 8'(a)); wr(4'd1, 8'(a >> 8));
    wr(4'd2, 8'(b)); wr(4'd3, 8'(b >> 8));
    mA = a; mB = b;
  endtask

  task automatic setSum(input longint v);
    for (int i = 0; i < 5; i++) wr(4'(4 + i), 8'(v >> (8 * i)));
    mAcc = v & MASK40;
  endtask

  task automatic setStat(input logic [7:0] d);
    wr(4'd9, d);
    {mHard, mZero, mSoft, mNeg} = d[3:0];
  endtask

  task automatic runOp();
    @(negedge clk); opStart = 1'b1;
    @(negedge clk); opStart = 1'b0;
    @(negedge clk);
    modelStep();
  endtask

  task automatic doClear();
    @(negedge clk); accClear = 1'b1;
    @(negedge clk); accClear = 1'b0;
    mAcc = 0; {mHard, mZero, mSoft, mNeg} = 4'b0100;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    shortint vals[13] = '{0, 1, -1, 2, -2, 127, -128, 255, 256, 32767, -32768, 12345, -321};
    mAcc = 0; mA = 0; mB = 0;
    {mHard, mZero, mSoft, mNeg} = 4'b0100;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state of every register
    for (int i = 0; i < 9; i++) begin
      rd(4'(i), v);
      chk("R1", "reset byte", longint'(v), 0);
    end
    rd(4'd9, v);
    chk("R1", "reset status", longint'(v), 64'h04);

    // R2 and R3: only the low nibble of status is writable
    setStat(8'hFF);
    rd(4'd9, v); chk("R2", "upper nibble after 0xFF", longint'(v), 64'h0F);
    setStat(8'hA5);
    rd(4'd9, v); chk("R3", "status after 0xA5", longint'(v), 64'h05);
    setStat(8'h00);
    rd(4'd9, v); chk("R3", "status after 0x00", longint'(v), 64'h00);
    doClear();

    // R5: latency of the two stages
    setOps(3, 4);
    @(negedge clk); opStart = 1'b1;
    @(negedge clk); opStart = 1'b0; regAddr = 4'd4;
    #1 chk("R5", "sum after first edge", longint'(regRdData), 0);
    @(negedge clk); regAddr = 4'd4;
    #1 chk("R5", "sum after second edge", longint'(regRdData), 12);
    modelStep();
    checkSum("R5");

    // R6: exact cancellation gives zero
    setOps(-3, 4);
    runOp();
    checkSum("R6");

    // R4/R5/R6/R7/R8: sweep of operand pairs
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        setOps(int'(vals[i]), int'(vals[j]));
        rd(4'd0, v); chk("R4", "A low", longint'(v), longint'(mA & 32'hFF));
        rd(4'd1, v); chk("R4", "A high", longint'(v), longint'((mA >> 8) & 32'hFF));
        rd(4'd3, v); chk("R4", "B high", longint'(v), longint'((mB >> 8) & 32'hFF));
        runOp();
        checkSum("R5_R6_R7");
      end
    end

    // R8: soft overflow sets and clears itself
    doClear();
    setSum(64'h00_7FFF_FFFF);
    setOps(1, 1); runOp(); checkSum("R8 set");
    setOps(-1, 1); runOp(); checkSum("R8 cleared");

    // R9/R13: hard overflow on a crossing 0x7F -> 0x80
    setSum(64'h7F_FFFF_FFFF);
    setOps(1, 1); runOp(); checkSum("R9 up crossing");
    setOps(0, 0); runOp(); checkSum("R9 sticky");
    // R10: software write of 0 to bit 3
    setStat(8'h05);
    rd(4'd9, v); chk("R10", "hard cleared by write", longint'(v), 64'h05);
    // R9: crossing 0x80 -> 0x7F
    setSum(64'h80_0000_0000);
    setOps(-1, 1); runOp(); checkSum("R9 down crossing");
    // R10: clear control
    doClear(); checkSum("R10 clear");

    // R11: clear cancels an operation waiting in stage one
    setOps(100, 100);
    @(negedge clk); opStart = 1'b1;
    @(negedge clk); opStart = 1'b0; accClear = 1'b1;
    @(negedge clk); accClear = 1'b0;
    @(negedge clk);
    checkSum("R11");

    // R12: status write on the commit edge loses
    setOps(7, -3);
    @(negedge clk); opStart = 1'b1;
    @(negedge clk); opStart = 1'b0;
    regAddr = 4'd9; regWrData = 8'h0E; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
    modelStep();
    rd(4'd9, v); chk("R12", "hardware result kept", longint'(v), 64'h01);
    checkSum("R12");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule